// File: doc/BRIEF.md
# Mode-Selected Clock Ratio Resolver

This block sits in front of a fractional-N clock control loop. It turns the loop's stored configuration and a few slow board-level mode pins into a single output-to-input multiplication ratio. Four configuration sets are presented to it as flat vectors. Each set holds a 32-bit unsigned ratio and a 2-bit divide selector. Two global settings are also presented: a format flag and a 3-bit function code for the auxiliary mode pin. Two selector pins choose the active set. The auxiliary pin can enable a power-of-two divide of the chosen ratio.

The 32-bit ratio can be read in one of two fixed-point layouts: 20 integer bits with 12 fraction bits, or 12 integer bits with 20 fraction bits. Either way it is widened without loss to a common 40-bit value with 20 integer bits and 20 fraction bits. That value leaves the block on a valid/ready stream. A new value is offered whenever the resolved ratio differs from the last one sent. While valid is high and ready is low, the data holds still. Once the consumer accepts it, the newest resolved ratio is offered.

All mode pins pass through a two-flop synchronizer. Pin activity does two jobs. It raises a one-cycle relock request toward the loop. It also serves as the start-up handshake: `init_done` rises after three changes of the selector pins.

Top module: `clk_ratio_resolver`

## Requirements
- R1: Selector pin value 0, 1, 2, 3 picks configuration set 0, 1, 2, 3; set k occupies bits [32k+31:32k] of `cfg_ratio_flat` and bits [2k+1:2k] of `cfg_div_flat`.
- R2: With `cfg_hi_res`=1 the 32-bit ratio is read as 12.20 and appears on `ratio_data` zero-extended (0x0013A92A gives 0x000013A92A, integer part 1); with `cfg_hi_res`=0 it is read as 20.12 and appears shifted left by 8 (0x32000000 gives 0x3200000000, integer part 204800).
- R3: When `cfg_aux_func` is 3'b011 and the synchronized auxiliary pin is high, the normalized ratio is shifted right by 1, 2, 3 or 4 bits for divide codes 0, 1, 2, 3, and the bits shifted out are dropped.
- R4: For any other function code, or with the auxiliary pin low, the normalized ratio is passed on with no shift.
- R5: Every change of the synchronized selector pins produces `relock_req` high for exactly one cycle.
- R6: A change of the auxiliary pin alone produces a one-cycle `relock_req` only while `cfg_aux_func` is 3'b011, 3'b100, 3'b101 or 3'b110; for other codes it produces none.
- R7: `init_done` is low after reset and rises after the third change of the synchronized selector pins; it then stays high until reset.
- R8: A configuration change shows up on `ratio_data` with `ratio_valid` high one clock later. The first cycle after reset also offers a value. With `ratio_ready` high and no change, `ratio_valid` falls the next cycle.
- R9: While `ratio_valid` is high and `ratio_ready` low, `ratio_data` and `ratio_valid` hold. When the transfer completes, the newest resolved ratio is offered in the next cycle.
- R10: A selector change and an auxiliary change that reach the synchronizer output in the same cycle yield a single one-cycle relock request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ratio_flat | input | 128 | Four stored 32-bit ratios, set 0 in the low word |
| cfg_div_flat | input | 8 | Four 2-bit divide selectors, set 0 in the low bits |
| cfg_hi_res | input | 1 | Ratio layout: 1 = 12.20, 0 = 20.12 |
| cfg_aux_func | input | 3 | Function code of the auxiliary mode pin |
| mode_sel_pin | input | 2 | Asynchronous set-selector pins |
| mode_aux_pin | input | 1 | Asynchronous auxiliary mode pin |
| ratio_data | output | 40 | Effective ratio, unsigned 20.20 |
| ratio_valid | output | 1 | Ratio offer valid |
| ratio_ready | input | 1 | Consumer accepts the offer |
| relock_req | output | 1 | One-cycle request to reacquire lock |
| init_done | output | 1 | Start-up toggle handshake complete |

## Verification
Two functions can fall in the same cycle. The first case is the selector and auxiliary pins both changing while the divide-enable function code is active. That one event should trigger the relock path through both of its causes and also change the resolved ratio. The bench drives both pins at the same falling edge. It then counts exactly one relock pulse over the following window and expects the new set's ratio, shifted by that set's divide code. The second case is a ratio change that arrives while the stream is stalled; it is judged by checking that the held word stays unchanged until acceptance.

// File: rtl/crr_pkg.sv
package crr_pkg;
  localparam logic [2:0] AUXF_DIV_EN = 3'b011;
  localparam logic [2:0] AUXF_RELOCK_LO = 3'b011;
  localparam logic [2:0] AUXF_RELOCK_HI = 3'b110;

  function automatic logic aux_change_relocks(input logic [2:0] code);
    return (code >= AUXF_RELOCK_LO) && (code <= AUXF_RELOCK_HI);
  endfunction
endpackage

// File: rtl/crr_pin_sync.sv
module crr_pin_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [STAGES-1:0][W-1:0] chain_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= '0;
    end else begin
      chain_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      prev_q <= chain_q[STAGES-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/crr_ratio_path.sv
module crr_ratio_path #(
  parameter int NUM_SETS = 4,
  parameter int RATIO_W  = 32,
  parameter int DIV_W    = 2,
  parameter int HR_FRAC  = 20,
  parameter int HM_FRAC  = 12,
  parameter int OUT_FRAC = 20,
  parameter int OUT_W    = 40,
  localparam int SEL_W   = $clog2(NUM_SETS)
) (
  input  logic [NUM_SETS*RATIO_W-1:0] ratio_flat,
  input  logic [NUM_SETS*DIV_W-1:0]   div_flat,
  input  logic [SEL_W-1:0]            sel,
  input  logic                        hi_res,
  input  logic                        div_active,
  output logic [OUT_W-1:0]            ratio_o
);
  localparam int HR_SH = OUT_FRAC - HR_FRAC;
  localparam int HM_SH = OUT_FRAC - HM_FRAC;

  logic [RATIO_W-1:0] ratios [NUM_SETS];
  logic [DIV_W-1:0]   divs   [NUM_SETS];

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_unpack
    assign ratios[g] = ratio_flat[g*RATIO_W +: RATIO_W];
    assign divs[g]   = div_flat[g*DIV_W +: DIV_W];
  end

  logic [OUT_W-1:0] widened;
  logic [OUT_W-1:0] normalized;
  logic [DIV_W:0]   shift_amt;

  always_comb begin
    widened    = {{(OUT_W-RATIO_W){1'b0}}, ratios[sel]};
    normalized = hi_res ? (widened << HR_SH) : (widened << HM_SH);
    shift_amt  = {1'b0, divs[sel]} + (DIV_W+1)'(1);
    ratio_o    = div_active ? (normalized >> shift_amt) : normalized;
  end
endmodule

// File: rtl/crr_init_tracker.sv
module crr_init_tracker #(
  parameter int TOGGLES = 3,
  localparam int CW     = $clog2(TOGGLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic event_i,
  output logic done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                cnt_q <= '0;
    else if (event_i && cnt_q != CW'(TOGGLES)) cnt_q <= cnt_q + CW'(1);
  end

  assign done_o = (cnt_q == CW'(TOGGLES));
endmodule

// File: rtl/crr_out_stage.sv
module crr_out_stage #(
  parameter int OUT_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OUT_W-1:0] next_i,
  output logic [OUT_W-1:0] data_o,
  output logic             valid_o,
  input  logic             ready_i
);
  logic             primed_q;
  logic [OUT_W-1:0] data_q;
  logic             valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      valid_q  <= 1'b0;
      primed_q <= 1'b0;
    end else if (!valid_q || ready_i) begin
      if (!primed_q || next_i != data_q) begin
        data_q   <= next_i;
        valid_q  <= 1'b1;
        primed_q <= 1'b1;
      end else begin
        valid_q <= 1'b0;
      end
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/clk_ratio_resolver.sv
module clk_ratio_resolver #(
  parameter int NUM_SETS    = 4,
  parameter int RATIO_W     = 32,
  parameter int DIV_W       = 2,
  parameter int HR_FRAC     = 20,
  parameter int HM_FRAC     = 12,
  parameter int OUT_FRAC    = 20,
  parameter int OUT_INT     = 20,
  parameter int SYNC_STAGES = 2,
  parameter int INIT_TOGGLES = 3,
  localparam int SEL_W      = $clog2(NUM_SETS),
  localparam int OUT_W      = OUT_INT + OUT_FRAC
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SETS*RATIO_W-1:0] cfg_ratio_flat,
  input  logic [NUM_SETS*DIV_W-1:0]   cfg_div_flat,
  input  logic                        cfg_hi_res,
  input  logic [2:0]                  cfg_aux_func,
  input  logic [SEL_W-1:0]            mode_sel_pin,
  input  logic                        mode_aux_pin,
  output logic [OUT_W-1:0]            ratio_data,
  output logic                        ratio_valid,
  input  logic                        ratio_ready,
  output logic                        relock_req,
  output logic                        init_done
);
  import crr_pkg::*;

  localparam int PIN_W = SEL_W + 1;

  logic [PIN_W-1:0] pins_s, pins_p;
  logic [SEL_W-1:0] sel_s, sel_p;
  logic             aux_s, aux_p;
  logic             sel_chg, aux_chg;
  logic             relock_q;
  logic [OUT_W-1:0] next_ratio;

  crr_pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({mode_aux_pin, mode_sel_pin}),
    .sync_o  (pins_s),
    .prev_o  (pins_p)
  );

  assign sel_s   = pins_s[SEL_W-1:0];
  assign sel_p   = pins_p[SEL_W-1:0];
  assign aux_s   = pins_s[PIN_W-1];
  assign aux_p   = pins_p[PIN_W-1];
  assign sel_chg = (sel_s != sel_p);
  assign aux_chg = (aux_s != aux_p);

  crr_ratio_path #(
    .NUM_SETS(NUM_SETS), .RATIO_W(RATIO_W), .DIV_W(DIV_W),
    .HR_FRAC(HR_FRAC), .HM_FRAC(HM_FRAC), .OUT_FRAC(OUT_FRAC), .OUT_W(OUT_W)
  ) u_path (
    .ratio_flat (cfg_ratio_flat),
    .div_flat   (cfg_div_flat),
    .sel        (sel_s),
    .hi_res     (cfg_hi_res),
    .div_active ((cfg_aux_func == AUXF_DIV_EN) && aux_s),
    .ratio_o    (next_ratio)
  );

  crr_out_stage #(.OUT_W(OUT_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .next_i  (next_ratio),
    .data_o  (ratio_data),
    .valid_o (ratio_valid),
    .ready_i (ratio_ready)
  );

  crr_init_tracker #(.TOGGLES(INIT_TOGGLES)) u_init (
    .clk     (clk),
    .rst_n   (rst_n),
    .event_i (sel_chg),
    .done_o  (init_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) relock_q <= 1'b0;
    else        relock_q <= sel_chg | (aux_chg & aux_change_relocks(cfg_aux_func));
  end

  assign relock_req = relock_q;
endmodule

// File: rtl/crr_checker.sv
module crr_checker #(
  parameter int SEL_W = 2,
  parameter int OUT_W = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] sel_sync,
  input logic [2:0]       aux_func,
  input logic             relock_req,
  input logic             init_done,
  input logic             ratio_valid,
  input logic             ratio_ready,
  input logic [OUT_W-1:0] ratio_data
);
  // R5: a synchronized selector change requests relock in the next cycle
  a_r5_sel_relock: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_sync != $past(sel_sync)) |=> relock_req);

  // R6: no selector change and a non-relocking code give no request
  a_r6_aux_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_sync == $past(sel_sync)) && (aux_func < 3'd3 || aux_func > 3'd6)) |=> !relock_req);

  // R7: once done, the handshake flag stays set
  a_r7_init_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R9: a stalled offer keeps its word and its valid
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_valid && !ratio_ready) |=> (ratio_valid && $stable(ratio_data)));
endmodule

bind clk_ratio_resolver crr_checker #(.SEL_W(SEL_W), .OUT_W(OUT_W)) u_crr_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .sel_sync    (sel_s),
  .aux_func    (cfg_aux_func),
  .relock_req  (relock_req),
  .init_done   (init_done),
  .ratio_valid (ratio_valid),
  .ratio_ready (ratio_ready),
  .ratio_data  (ratio_data)
);

// File: tb/clk_ratio_resolver_bench.sv
module clk_ratio_resolver_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] cfg_ratio_flat;
  logic [7:0]   cfg_div_flat;
  logic         cfg_hi_res;
  logic [2:0]   cfg_aux_func;
  logic [1:0]   mode_sel_pin;
  logic         mode_aux_pin;
  logic [39:0]  ratio_data;
  logic         ratio_valid;
  logic         ratio_ready;
  logic         relock_req;
  logic         init_done;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  clk_ratio_resolver u_clk_ratio_resolver (
    .clk(clk), .rst_n(rst_n), .cfg_ratio_flat(cfg_ratio_flat), .cfg_div_flat(cfg_div_flat),
    .cfg_hi_res(cfg_hi_res), .cfg_aux_func(cfg_aux_func), .mode_sel_pin(mode_sel_pin),
    .mode_aux_pin(mode_aux_pin), .ratio_data(ratio_data), .ratio_valid(ratio_valid),
    .ratio_ready(ratio_ready), .relock_req(relock_req), .init_done(init_done)
  );

  function automatic logic [39:0] model(input logic [31:0] r, input logic hi, input logic [2:0] fn,
                                        input logic aux, input logic [1:0] dv);
    logic [39:0] v;
    v = hi ? {8'h00, r} : {r, 8'h00};
    if (fn == 3'b011 && aux) v = v >> (int'(dv) + 1);
    return v;
  endfunction

  function automatic logic [39:0] expect_now();
    return model(cfg_ratio_flat[32*mode_sel_pin +: 32], cfg_hi_res, cfg_aux_func,
                 mode_aux_pin, cfg_div_flat[2*mode_sel_pin +: 2]);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_relock(input int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (relock_req) c++;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    tick(3);
    chk(!ratio_valid && !relock_req && !init_done, "R7 reset state",
        {ratio_valid, relock_req, init_done}, 0);
    rst_n = 1'b1;
    tick(1);
    chk(ratio_valid && ratio_data == 40'h000013A92A, "R8 first offer after reset",
        {ratio_valid, ratio_data}, {1'b1, 40'h000013A92A});
    tick(1);
    chk(!ratio_valid, "R8 valid falls when idle", ratio_valid, 0);
  endtask

  task automatic t_init();
    int c;
    mode_sel_pin = 2'd1; count_relock(8, c);
    mode_sel_pin = 2'd0; count_relock(8, c);
    chk(!init_done, "R7 not done after two toggles", init_done, 0);
    mode_sel_pin = 2'd1; count_relock(8, c);
    chk(init_done, "R7 done after third toggle", init_done, 1);
  endtask

  task automatic t_select();
    int c;
    int order [4] = '{0, 2, 3, 1};
    foreach (order[i]) begin
      mode_sel_pin = 2'(order[i]);
      count_relock(8, c);
      chk(c == 1, "R5 one relock pulse per selector change", c, 1);
      chk(ratio_data == expect_now(), "R1 set selection", ratio_data, expect_now());
    end
  endtask

  task automatic t_format();
    mode_sel_pin = 2'd0;
    tick(8);
    cfg_ratio_flat[31:0] = 32'h32000000; cfg_hi_res = 1'b0;
    tick(1);
    chk(ratio_valid && ratio_data == 40'h3200000000, "R2 20.12 layout / R8 one-cycle update",
        ratio_data, 40'h3200000000);
    chk(ratio_data[39:20] == 20'd204800, "R2 integer part 204800", ratio_data[39:20], 204800);
    tick(1);
    chk(!ratio_valid, "R8 valid low with no change", ratio_valid, 0);
    cfg_ratio_flat[31:0] = 32'h0013A92A; cfg_hi_res = 1'b1;
    tick(1);
    chk(ratio_data == 40'h000013A92A && ratio_data[39:20] == 20'd1, "R2 12.20 layout",
        ratio_data, 40'h000013A92A);
  endtask

  task automatic t_divide();
    int c;
    for (int k = 0; k < 4; k++) cfg_ratio_flat[32*k +: 32] = 32'h0013A92A;
    cfg_aux_func = 3'b011; mode_aux_pin = 1'b1;
    for (int s = 0; s < 4; s++) begin
      mode_sel_pin = 2'(s);
      count_relock(8, c);
      chk(ratio_data == (40'h000013A92A >> (s + 1)), "R3 divide shift",
          ratio_data, 40'h000013A92A >> (s + 1));
    end
  endtask

  task automatic t_bypass();
    cfg_aux_func = 3'b100;
    tick(4);
    chk(ratio_data == 40'h000013A92A, "R4 no shift for other code", ratio_data, 40'h000013A92A);
    cfg_aux_func = 3'b011; mode_aux_pin = 1'b0;
    tick(6);
    chk(ratio_data == 40'h000013A92A, "R4 no shift with pin low", ratio_data, 40'h000013A92A);
  endtask

  task automatic t_aux_relock();
    int c;
    logic [2:0] codes [4] = '{3'b011, 3'b101, 3'b000, 3'b111};
    int expc [4] = '{1, 1, 0, 0};
    foreach (codes[i]) begin
      cfg_aux_func = codes[i];
      tick(8);
      mode_aux_pin = ~mode_aux_pin;
      count_relock(8, c);
      chk(c == expc[i], "R6 auxiliary change relock by code", c, expc[i]);
    end
  endtask

  task automatic t_backpressure();
    cfg_aux_func = 3'b000;
    tick(8);
    ratio_ready = 1'b0;
    cfg_ratio_flat[32*mode_sel_pin +: 32] = 32'h00200000;
    tick(1);
    chk(ratio_valid && ratio_data == 40'h0000200000, "R9 stalled offer presented",
        ratio_data, 40'h0000200000);
    cfg_ratio_flat[32*mode_sel_pin +: 32] = 32'h00300000;
    tick(3);
    chk(ratio_valid && ratio_data == 40'h0000200000, "R9 word held while stalled",
        ratio_data, 40'h0000200000);
    ratio_ready = 1'b1;
    tick(1);
    chk(ratio_valid && ratio_data == 40'h0000300000, "R9 newest offered after accept",
        ratio_data, 40'h0000300000);
    tick(1);
    chk(!ratio_valid, "R9 valid drops after second accept", ratio_valid, 0);
  endtask

  task automatic t_coincident();
    int c;
    cfg_ratio_flat = {4{32'h0013A92A}};
    cfg_aux_func = 3'b011; mode_aux_pin = 1'b0; mode_sel_pin = 2'd0;
    tick(10);
    mode_sel_pin = 2'd2; mode_aux_pin = 1'b1;
    count_relock(8, c);
    chk(c == 1, "R10 single relock for joint change", c, 1);
    chk(ratio_data == (40'h000013A92A >> 3), "R10 joint change ratio", ratio_data,
        40'h000013A92A >> 3);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    cfg_ratio_flat = {32'h12345678, 32'h00100000, 32'h32000000, 32'h0013A92A};
    cfg_div_flat   = {2'd3, 2'd2, 2'd1, 2'd0};
    cfg_hi_res     = 1'b1;
    cfg_aux_func   = 3'b000;
    mode_sel_pin   = 2'd0;
    mode_aux_pin   = 1'b0;
    ratio_ready    = 1'b1;
    t_reset();
    t_init();
    t_select();
    t_format();
    t_divide();
    t_bypass();
    t_aux_relock();
    t_backpressure();
    t_coincident();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule